// File: doc/BRIEF.md
# Next-PC Sequencer with Delay Slot and Return Stack

This block owns the program counter of a small microcontroller and decides, each time an instruction retires, where the next fetch comes from. The decoder gives it a transfer type and the operands it needs: a source register value, a 5-bit immediate or bit index, a 16-bit relative offset and a 26-bit absolute target. From these it produces the next PC. It also drives a write of the return address into the link register and push and pop pulses for its own return-address stack.

A taken transfer does not redirect at once. The instruction that follows it, the delay slot, always executes first. The sequencer holds the target and applies it when the slot instruction retires. Two return mechanisms sit side by side. Branch-and-link writes the return address to the link register, and an indirect jump through that register returns from it. Call and return use an 8-entry hardware stack. A third path, interrupt-return, resumes at a PC that the preemption logic stored earlier. A secure-mode switch that succeeds skips the next two instructions.

Top module: `npc_sequencer`

## Requirements
- R1: After reset the PC equals RESET_PC (0), no delay slot is pending, the stack is empty, and lr_we_o, push_o, pop_o, ovf_err_o and udf_err_o are low.
- R2: op_i codes are: 0 none, 1 branch-if-equal-immediate, 2 branch-if-not-equal-immediate, 3 branch-if-bit-set, 4 branch-if-bit-clear, 5 indirect jump, 6 absolute jump, 7 branch-and-link, 8 call, 9 return, 10 interrupt-return, 11 secure switch; codes 12 to 15 act as none. A step with no taken transfer moves the PC to PC+1. Without step_i the PC holds.
- R3: Code 1 is taken when src_i equals imm_i zero-extended, and code 2 when it differs.
- R4: Code 3 is taken when bit imm_i of src_i is 1, and code 4 when that bit is 0. Code 4 with src_i=0 and imm_i=0 is an unconditional jump.
- R5: The target of codes 1–4 is PC + sign-extended off_i. Codes 6–8 use the low PCW bits of abs_i. Code 5 uses the low PCW bits of src_i.
- R6: A taken transfer moves the PC to PC+1 and raises in_slot_o. The next step moves the PC to the held target and clears in_slot_o.
- R7: A step in the delay slot ignores op_i. It causes no push, pop, link write or error, and the PC still goes to the held target.
- R8: Branch-and-link pulses lr_we_o for one cycle with lr_addr_o = 27 and lr_data_o = PC+2, zero-extended.
- R9: Call pushes PC+2 and pulses push_o. Return pops and pulses pop_o, and targets the entry pushed most recently (last-in, first-out).
- R10: A call with 8 entries already on the stack writes nothing, pulses ovf_err_o, leaves the depth at 8, and still makes the transfer.
- R11: A return on an empty stack pulses udf_err_o, does not pulse pop_o, and makes no transfer (PC+1).
- R12: Interrupt-return targets the value last written through epc_we_i. A write in the same cycle takes effect only for later steps.
- R13: A secure switch with skip_ok_i high moves the PC to PC+3 with no delay slot. With skip_ok_i low it moves to PC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | The instruction at pc_o retires this cycle |
| op_i | input | 4 | Decoded transfer type |
| src_i | input | DW | Source register value |
| imm_i | input | 5 | Compare immediate or bit index |
| off_i | input | 16 | Relative branch offset |
| abs_i | input | 26 | Absolute target |
| skip_ok_i | input | 1 | The secure switch succeeded |
| epc_we_i | input | 1 | Store a resume PC |
| epc_d_i | input | PCW | Resume PC to store |
| pc_o | output | PCW | Current program counter |
| in_slot_o | output | 1 | The instruction at pc_o is a delay slot |
| lr_we_o | output | 1 | Link register write enable |
| lr_addr_o | output | 5 | Link register index (27) |
| lr_data_o | output | DW | Return address to write |
| push_o | output | 1 | Return stack pushed |
| pop_o | output | 1 | Return stack popped |
| ovf_err_o | output | 1 | Push on a full stack |
| udf_err_o | output | 1 | Pop on an empty stack |

## Verification
Two functions can land in the same cycle: the delay-slot redirect and a stack or link operation decoded in that slot. The bench places call, return, branch-and-link and conditional ops directly after taken transfers, both directed and at random. It then checks that the PC reaches the held target and that no push, pop, link write or error pulse appears. A second collision is a resume-PC write in the same cycle as interrupt-return, which must still use the older value. Random steps are compared cycle by cycle with a reference model kept in the bench.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;
  typedef enum logic [3:0] {
    XF_NONE   = 4'd0,
    XF_BEQI   = 4'd1,
    XF_BNEI   = 4'd2,
    XF_BBSET  = 4'd3,
    XF_BBCLR  = 4'd4,
    XF_JREG   = 4'd5,
    XF_JABS   = 4'd6,
    XF_BL     = 4'd7,
    XF_CALL   = 4'd8,
    XF_RET    = 4'd9,
    XF_IRET   = 4'd10,
    XF_SECURE = 4'd11
  } xfer_e;
endpackage

// File: rtl/npc_cond.sv
`timescale 1ns/1ps
module npc_cond
  import npc_pkg::*;
#(
  parameter int DW = 32
) (
  input  xfer_e          op_i,
  input  logic [DW-1:0]  src_i,
  input  logic [4:0]     imm_i,
  output logic           pass_o
);
  logic eq_imm;
  logic sel_bit;

  assign eq_imm  = (src_i == DW'(imm_i));
  assign sel_bit = src_i[imm_i];

  always_comb begin
    case (op_i)
      XF_BEQI:  pass_o = eq_imm;
      XF_BNEI:  pass_o = !eq_imm;
      XF_BBSET: pass_o = sel_bit;
      XF_BBCLR: pass_o = !sel_bit;
      default:  pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
`timescale 1ns/1ps
module npc_target
  import npc_pkg::*;
#(
  parameter int PCW = 20,
  parameter int DW  = 32
) (
  input  xfer_e           op_i,
  input  logic [PCW-1:0]  pc_i,
  input  logic [15:0]     off_i,
  input  logic [25:0]     abs_i,
  input  logic [DW-1:0]   src_i,
  input  logic [PCW-1:0]  stk_top_i,
  input  logic [PCW-1:0]  epc_i,
  output logic [PCW-1:0]  tgt_o
);
  logic [PCW-1:0] rel_ext;
  logic [PCW-1:0] abs_ext;

  generate
    if (PCW > 16) begin : g_rel_wide
      assign rel_ext = {{(PCW-16){off_i[15]}}, off_i};
    end else begin : g_rel_narrow
      assign rel_ext = off_i[PCW-1:0];
    end
    if (PCW > 26) begin : g_abs_wide
      assign abs_ext = {{(PCW-26){1'b0}}, abs_i};
    end else if (PCW == 26) begin : g_abs_exact
      assign abs_ext = abs_i;
    end else begin : g_abs_narrow
      assign abs_ext = abs_i[PCW-1:0];
    end
  endgenerate

  always_comb begin
    case (op_i)
      XF_BEQI, XF_BNEI, XF_BBSET, XF_BBCLR: tgt_o = pc_i + rel_ext;
      XF_JREG:                             tgt_o = src_i[PCW-1:0];
      XF_JABS, XF_BL, XF_CALL:             tgt_o = abs_ext;
      XF_RET:                              tgt_o = stk_top_i;
      XF_IRET:                             tgt_o = epc_i;
      default:                             tgt_o = pc_i + PCW'(1);
    endcase
  end
endmodule

// File: rtl/npc_rstack.sv
`timescale 1ns/1ps
module npc_rstack #(
  parameter int DEPTH = 8,
  parameter int W     = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] top_idx;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign top_idx = cnt - CW'(1);
  assign top_o   = mem[top_idx[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push_i && !full_o) mem[cnt[AW-1:0]] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (push_i && !full_o) begin
      cnt <= cnt + CW'(1);
    end else if (pop_i && !empty_o) begin
      cnt <= cnt - CW'(1);
    end
  end

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R10
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (push_i && full_o) |=> full_o); // R10
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && empty_o) |=> empty_o); // R11
endmodule

// File: rtl/npc_sequencer.sv
`timescale 1ns/1ps
module npc_sequencer
  import npc_pkg::*;
#(
  parameter int PCW       = 20,
  parameter int DW        = 32,
  parameter int STK_DEPTH = 8,
  parameter int LINK_REG  = 27,
  parameter int RESET_PC  = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step_i,
  input  logic [3:0]     op_i,
  input  logic [DW-1:0]  src_i,
  input  logic [4:0]     imm_i,
  input  logic [15:0]    off_i,
  input  logic [25:0]    abs_i,
  input  logic           skip_ok_i,
  input  logic           epc_we_i,
  input  logic [PCW-1:0] epc_d_i,
  output logic [PCW-1:0] pc_o,
  output logic           in_slot_o,
  output logic           lr_we_o,
  output logic [4:0]     lr_addr_o,
  output logic [DW-1:0]  lr_data_o,
  output logic           push_o,
  output logic           pop_o,
  output logic           ovf_err_o,
  output logic           udf_err_o
);
  xfer_e          op;
  logic           slot_q;
  logic [PCW-1:0] pc_q, tgt_q, epc_q;
  logic [PCW-1:0] pc_inc1, pc_inc2, pc_inc3;
  logic           cond_pass, taken, exec, redirect, skip;
  logic           push_req, pop_req, ovf, udf;
  logic [PCW-1:0] tgt, stk_top;
  logic           stk_full, stk_empty;

  assign op      = xfer_e'(op_i);
  assign pc_inc1 = pc_q + PCW'(1);
  assign pc_inc2 = pc_q + PCW'(2);
  assign pc_inc3 = pc_q + PCW'(3);
  assign exec    = step_i && !slot_q;

  npc_cond #(.DW(DW)) u_cond (
    .op_i(op), .src_i(src_i), .imm_i(imm_i), .pass_o(cond_pass)
  );

  npc_target #(.PCW(PCW), .DW(DW)) u_tgt (
    .op_i(op), .pc_i(pc_q), .off_i(off_i), .abs_i(abs_i), .src_i(src_i),
    .stk_top_i(stk_top), .epc_i(epc_q), .tgt_o(tgt)
  );

  npc_rstack #(.DEPTH(STK_DEPTH), .W(PCW)) u_stk (
    .clk(clk), .rst(rst), .push_i(push_req), .pop_i(pop_req),
    .data_i(pc_inc2), .top_o(stk_top), .full_o(stk_full), .empty_o(stk_empty)
  );

  always_comb begin
    case (op)
      XF_BEQI, XF_BNEI, XF_BBSET, XF_BBCLR: taken = cond_pass;
      XF_JREG, XF_JABS, XF_BL, XF_CALL, XF_IRET: taken = 1'b1;
      XF_RET:  taken = !stk_empty;
      default: taken = 1'b0;
    endcase
  end

  assign redirect = exec && taken;
  assign skip     = exec && (op == XF_SECURE) && skip_ok_i;
  assign push_req = exec && (op == XF_CALL);
  assign pop_req  = exec && (op == XF_RET) && !stk_empty;
  assign ovf      = push_req && stk_full;
  assign udf      = exec && (op == XF_RET) && stk_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= PCW'(RESET_PC);
      slot_q <= 1'b0;
      tgt_q  <= '0;
    end else if (step_i) begin
      if (slot_q) begin
        pc_q   <= tgt_q;
        slot_q <= 1'b0;
      end else if (redirect) begin
        pc_q   <= pc_inc1;
        tgt_q  <= tgt;
        slot_q <= 1'b1;
      end else if (skip) begin
        pc_q   <= pc_inc3;
      end else begin
        pc_q   <= pc_inc1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q     <= '0;
      lr_we_o   <= 1'b0;
      lr_data_o <= '0;
      push_o    <= 1'b0;
      pop_o     <= 1'b0;
      ovf_err_o <= 1'b0;
      udf_err_o <= 1'b0;
    end else begin
      if (epc_we_i) epc_q <= epc_d_i;
      lr_we_o   <= exec && (op == XF_BL);
      lr_data_o <= {{(DW-PCW){1'b0}}, pc_inc2};
      push_o    <= push_req && !stk_full;
      pop_o     <= pop_req;
      ovf_err_o <= ovf;
      udf_err_o <= udf;
    end
  end

  assign pc_o      = pc_q;
  assign in_slot_o = slot_q;
  assign lr_addr_o = 5'(LINK_REG);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> (pc_o == $past(pc_o))); // R2
  AST_SLOT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (step_i && !in_slot_o && taken) |=> (in_slot_o && pc_o == $past(pc_o) + PCW'(1))); // R6
  AST_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (step_i && in_slot_o) |=> (!push_o && !pop_o && !lr_we_o && !ovf_err_o && !udf_err_o && !in_slot_o)); // R7
  AST_LINK_ADDR: assert property (@(posedge clk) disable iff (rst)
    (step_i && !in_slot_o && op == XF_BL) |=> (lr_we_o && lr_data_o[PCW-1:0] == $past(pc_o) + PCW'(2))); // R8
  AST_UNDERFLOW_QUIET: assert property (@(posedge clk) disable iff (rst)
    udf_err_o |-> (!pop_o && !in_slot_o)); // R11
  AST_SKIP_TWO: assert property (@(posedge clk) disable iff (rst)
    (step_i && !in_slot_o && op == XF_SECURE && skip_ok_i) |=> (pc_o == $past(pc_o) + PCW'(3))); // R13
endmodule

// File: tb/sim_npc_sequencer.sv
`timescale 1ns/1ps
module sim_npc_sequencer;
  localparam int PCW = 20;
  localparam int DW  = 32;
  localparam int OP_NONE = 0, OP_BEQI = 1, OP_BNEI = 2, OP_BBSET = 3, OP_BBCLR = 4,
                 OP_JREG = 5, OP_JABS = 6, OP_BL = 7, OP_CALL = 8, OP_RET = 9,
                 OP_IRET = 10, OP_SEC = 11;

  logic clk = 1'b0;
  logic rst;
  logic step_i;
  logic [3:0] op_i;
  logic [DW-1:0] src_i;
  logic [4:0] imm_i;
  logic [15:0] off_i;
  logic [25:0] abs_i;
  logic skip_ok_i, epc_we_i;
  logic [PCW-1:0] epc_d_i;
  logic [PCW-1:0] pc_o;
  logic in_slot_o, lr_we_o, push_o, pop_o, ovf_err_o, udf_err_o;
  logic [4:0] lr_addr_o;
  logic [DW-1:0] lr_data_o;

  always #4 clk = ~clk;

  npc_sequencer u0 (
    .clk(clk), .rst(rst), .step_i(step_i), .op_i(op_i), .src_i(src_i),
    .imm_i(imm_i), .off_i(off_i), .abs_i(abs_i), .skip_ok_i(skip_ok_i),
    .epc_we_i(epc_we_i), .epc_d_i(epc_d_i), .pc_o(pc_o), .in_slot_o(in_slot_o),
    .lr_we_o(lr_we_o), .lr_addr_o(lr_addr_o), .lr_data_o(lr_data_o),
    .push_o(push_o), .pop_o(pop_o), .ovf_err_o(ovf_err_o), .udf_err_o(udf_err_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [PCW-1:0] m_pc, m_tgt, m_epc;
  logic [PCW-1:0] m_stk [8];
  int m_cnt;
  bit m_slot;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PCW-1:0] sext(logic [15:0] o);
    return {{(PCW-16){o[15]}}, o};
  endfunction

  task automatic drive(bit st, int op, logic [DW-1:0] s, logic [4:0] im,
                       logic [15:0] of, logic [25:0] ab, bit sk, bit ew, logic [PCW-1:0] ed);
    bit exec, tk, e_lr, e_push, e_pop, e_ovf, e_udf;
    logic [PCW-1:0] tgt, npc;
    bit nslot;
    string tg;
    @(negedge clk);
    step_i = st; op_i = 4'(op); src_i = s; imm_i = im; off_i = of; abs_i = ab;
    skip_ok_i = sk; epc_we_i = ew; epc_d_i = ed;
    exec = st && !m_slot;
    tk = 0; tgt = m_pc + 1;
    case (op)
      OP_BEQI:  begin tk = (s == DW'(im)); tgt = m_pc + sext(of); end
      OP_BNEI:  begin tk = (s != DW'(im)); tgt = m_pc + sext(of); end
      OP_BBSET: begin tk = s[im];          tgt = m_pc + sext(of); end
      OP_BBCLR: begin tk = !s[im];         tgt = m_pc + sext(of); end
      OP_JREG:  begin tk = 1; tgt = s[PCW-1:0]; end
      OP_JABS, OP_BL, OP_CALL: begin tk = 1; tgt = ab[PCW-1:0]; end
      OP_RET:   begin tk = (m_cnt > 0); if (m_cnt > 0) tgt = m_stk[m_cnt-1]; end
      OP_IRET:  begin tk = 1; tgt = m_epc; end
      default:  tk = 0;
    endcase
    if (!st) tg = "R2";
    else if (m_slot) tg = "R7";
    else case (op)
      OP_BEQI, OP_BNEI: tg = "R3";
      OP_BBSET, OP_BBCLR: tg = "R4";
      OP_JREG, OP_JABS: tg = "R5";
      OP_BL: tg = "R8";
      OP_CALL: tg = (m_cnt == 8) ? "R10" : "R9";
      OP_RET: tg = (m_cnt == 0) ? "R11" : "R9";
      OP_IRET: tg = "R12";
      OP_SEC: tg = "R13";
      default: tg = "R2";
    endcase
    e_lr   = exec && op == OP_BL;
    e_push = exec && op == OP_CALL && m_cnt < 8;
    e_ovf  = exec && op == OP_CALL && m_cnt == 8;
    e_pop  = exec && op == OP_RET && m_cnt > 0;
    e_udf  = exec && op == OP_RET && m_cnt == 0;
    npc = m_pc; nslot = m_slot;
    if (st) begin
      if (m_slot) begin npc = m_tgt; nslot = 0; end
      else if (tk) begin npc = m_pc + 1; nslot = 1; m_tgt = tgt; end
      else if (op == OP_SEC && sk) npc = m_pc + 3;
      else npc = m_pc + 1;
    end
    if (e_push) begin m_stk[m_cnt] = m_pc + 2; m_cnt++; end
    if (e_pop) m_cnt--;
    @(posedge clk); #1;
    chk({tg, " pc"}, 64'(pc_o), 64'(npc));
    chk({(tk && exec) ? "R6" : tg, " in_slot"}, 64'(in_slot_o), 64'(nslot));
    chk({tg, " lr_we"}, 64'(lr_we_o), 64'(e_lr));
    if (e_lr) begin
      chk("R8 lr_data", 64'(lr_data_o), 64'(m_pc + 2));
      chk("R8 lr_addr", 64'(lr_addr_o), 64'd27);
    end
    chk({tg, " push"}, 64'(push_o), 64'(e_push));
    chk({tg, " pop"}, 64'(pop_o), 64'(e_pop));
    chk({tg, " ovf"}, 64'(ovf_err_o), 64'(e_ovf));
    chk({tg, " udf"}, 64'(udf_err_o), 64'(e_udf));
    m_pc = npc; m_slot = nslot;
    if (ew) m_epc = ed;
  endtask

  task automatic st0(int op);
    drive(1, op, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; step_i = 0; op_i = 0; src_i = 0; imm_i = 0; off_i = 0; abs_i = 0;
    skip_ok_i = 0; epc_we_i = 0; epc_d_i = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    m_pc = 0; m_slot = 0; m_cnt = 0; m_epc = 0; m_tgt = 0;
    #1;
    // R1 reset state
    chk("R1 pc", 64'(pc_o), 64'd0);
    chk("R1 in_slot", 64'(in_slot_o), 64'd0);
    chk("R1 pulses", 64'({lr_we_o, push_o, pop_o, ovf_err_o, udf_err_o}), 64'd0);
    // R11 empty stack right after reset
    st0(OP_RET);
    // R2 idle hold and plain steps
    drive(0, OP_JABS, 0, 0, 0, 26'h100, 0, 0, 0);
    st0(OP_NONE); st0(15);
    // R4 unconditional jump: bit-clear on zero source, bit 0, backwards
    drive(1, OP_BBCLR, 0, 0, 16'hFFFE, 0, 0, 0, 0);
    st0(OP_NONE);
    // R7 call in delay slot ignored
    drive(1, OP_JABS, 0, 0, 0, 26'h3FF_0040, 0, 0, 0);
    st0(OP_CALL);
    drive(1, OP_BL, 0, 0, 0, 26'h200, 0, 0, 0);
    st0(OP_RET);
    // R9 nested calls then returns; R10 overflow at 9th
    for (int i = 0; i < 9; i++) begin
      drive(1, OP_CALL, 0, 0, 0, 26'(32'h1000 + i * 16), 0, 0, 0);
      st0(OP_NONE);
    end
    for (int i = 0; i < 9; i++) begin
      st0(OP_RET);
      st0(OP_NONE);
    end
    // R12 iret with concurrent epc write
    drive(1, OP_NONE, 0, 0, 0, 0, 0, 1, 20'h0ABC0);
    drive(1, OP_IRET, 0, 0, 0, 0, 0, 1, 20'h01230);
    st0(OP_NONE);
    st0(OP_IRET);
    st0(OP_NONE);
    // R13 secure switch
    drive(1, OP_SEC, 0, 0, 0, 0, 1, 0, 0);
    drive(1, OP_SEC, 0, 0, 0, 0, 0, 0, 0);
    // R3 equal and not equal
    drive(1, OP_BEQI, 32'd17, 5'd17, 16'h0010, 0, 0, 0, 0);
    st0(OP_NONE);
    drive(1, OP_BNEI, 32'h100_0011, 5'd17, 16'h8000, 0, 0, 0, 0);
    st0(OP_NONE);
    // R5 indirect jump
    drive(1, OP_JREG, 32'hFFF1_2345, 0, 0, 0, 0, 0, 0);
    st0(OP_NONE);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [DW-1:0] s;
      logic [4:0] im;
      op = int'($urandom_range(0, 12));
      s = $urandom;
      im = 5'($urandom);
      if ($urandom_range(0, 3) == 0) s = DW'(im);
      drive($urandom_range(0, 7) != 0, op, s, im, 16'($urandom), 26'($urandom),
            1'($urandom), $urandom_range(0, 5) == 0, PCW'($urandom));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule